// File: doc/BRIEF.md
# Configurable Decade Counter Pair (Divide-by-2 and Divide-by-5 Stages)

The block holds a number of identical counter halves, two by default. Each half has a one-bit divide-by-2 stage and a divide-by-5 stage. Each stage has its own count input. All logic runs on one system clock. The count inputs are treated as slow external signals. Each one passes through a synchronizer, and only a high-to-low transition seen on it advances the matching stage. A rising transition does nothing.

A two-bit arrangement code per half selects how the stages are chained. In the split arrangement the stages count separately, so one half gives a divide-by-2 and a divide-by-5. In the BCD arrangement the divide-by-2 output feeds the divide-by-5 stage, and the four outputs run 0 to 9 in plain binary. In the bi-quinary arrangement the divide-by-5 stage takes the external count, and its wrap from 4 to 0 toggles the divide-by-2 output. That output then becomes a square-wave divide-by-10.

Each half has its own active-high reset. The reset is taken in asynchronously and released in step with the clock. It clears all four outputs of that half.

Top module: `dual_decade_counter`

## Requirements
- R1: A stage advances only on a high-to-low transition of the count input that drives it. A low-to-high transition leaves every output unchanged. Each transition advances a stage at most once.
- R2: While a half's reset is high, that half's four outputs read 0, and they go to 0 as soon as reset rises. Count transitions that occur while reset is high are discarded. After release the half counts from 0.
- R3: In the split arrangement (code 2'b00), each falling edge on the half's first count input toggles bit 0 of its output nibble.
- R4: The divide-by-5 stage occupies nibble bits 3:1, with bit 1 as the least significant bit. It steps through 0, 1, 2, 3, 4 and then wraps to 0. Bit 3 is high only in state 4. In the split arrangement it is advanced by the second count input.
- R5: In the BCD arrangement (code 2'b01), the first count input drives bit 0. Each 1-to-0 step of bit 0 advances the divide-by-5 stage, so the nibble counts 0 to 9 in binary and then returns to 0. The second count input has no effect.
- R6: In the bi-quinary arrangement (code 2'b10), the second count input drives the divide-by-5 stage. Each wrap of that stage from 4 to 0 toggles bit 0, and the first count input has no effect.
- R7: Code 2'b11 behaves exactly as the split arrangement.
- R8: An internal carry between the stages takes effect in the same clock cycle as the edge that causes it. Both stages of a half change in that one cycle.
- R9: Each half responds only to its own reset, count inputs and code. Activity in one half never changes another half's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_i | input | N_HALVES | Active-high reset, one bit per half |
| cnt_a_i | input | N_HALVES | First count input (divide-by-2 stage), one bit per half |
| cnt_b_i | input | N_HALVES | Second count input (divide-by-5 stage), one bit per half |
| arr_i | input | 2*N_HALVES | Arrangement code, two bits per half, half h at bits 2h+1:2h |
| q_o | output | 4*N_HALVES | Outputs, four bits per half at bits 4h+3:4h; bit 0 divide-by-2, bits 3:1 divide-by-5 |

## Verification
The hardest case to reach from the ports is the cascade instant: both stages of a half must change in the very same clock cycle. A carry that lagged by a cycle would still give the right counts once the outputs settle. To catch that, the bench runs a half in the BCD arrangement up to an odd count and then lowers its first count input. It samples the outputs on every clock cycle and requires bit 0 and bits 3:1 to change on the same sample. Random runs then mix pulses, arrangement changes and resets in the middle of a count across both halves, so that wraps at 4 and 9 occur under many orderings.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;

  typedef enum logic [1:0] {
    ARR_SPLIT = 2'b00,
    ARR_BCD   = 2'b01,
    ARR_BIQ   = 2'b10,
    ARR_SPARE = 2'b11
  } arr_e;

  localparam int          QUIN_W   = 3;
  localparam logic [2:0]  QUIN_TOP = 3'd4;

  // next state of the divide-by-5 stage
  function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] s);
    return (s >= QUIN_TOP) ? '0 : s + 3'd1;
  endfunction

  // the spare code folds onto the split arrangement
  function automatic arr_e arr_decode(input logic [1:0] code);
    case (code)
      2'b01:   return ARR_BCD;
      2'b10:   return ARR_BIQ;
      default: return ARR_SPLIT;
    endcase
  endfunction

endpackage

// File: rtl/rst_bridge.sv
module rst_bridge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_i,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) chain <= '1;
    else       chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign fall_o = sh[STAGES] & ~sh[STAGES-1];

  // a single transition yields a one-cycle advance
  assert_fall_single_R1: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/decade_half.sv
module decade_half
  import dcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_i,
  input  logic       cnt_a_i,
  input  logic       cnt_b_i,
  input  logic [1:0] arr_i,
  output logic [3:0] q_o
);
  logic              rst_int;
  logic              fall_a, fall_b;
  logic              adv_two, adv_five;
  logic              two_q;
  logic [QUIN_W-1:0] five_q;
  arr_e              arr;

  rst_bridge #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_i(rst_i), .rst_o(rst_int));

  fall_detect #(.STAGES(SYNC_STAGES)) u_fa (
    .clk(clk), .rst(rst_int), .din(cnt_a_i), .fall_o(fall_a));

  fall_detect #(.STAGES(SYNC_STAGES)) u_fb (
    .clk(clk), .rst(rst_int), .din(cnt_b_i), .fall_o(fall_b));

  assign arr = arr_decode(arr_i);

  // stage advance enables, cascade resolved in the same cycle
  always_comb begin
    case (arr)
      ARR_BCD: begin
        adv_two  = fall_a;
        adv_five = fall_a & two_q;
      end
      ARR_BIQ: begin
        adv_two  = fall_b & (five_q == QUIN_TOP);
        adv_five = fall_b;
      end
      default: begin
        adv_two  = fall_a;
        adv_five = fall_b;
      end
    endcase
  end

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      two_q  <= 1'b0;
      five_q <= '0;
    end else begin
      if (adv_two)  two_q  <= ~two_q;
      if (adv_five) five_q <= quin_next(five_q);
    end
  end

  assign q_o = {five_q, two_q};

  assert_quin_range_R4: assert property (@(posedge clk) disable iff (rst_int)
    five_q <= QUIN_TOP);

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst_int |-> (q_o == 4'd0));

  assert_split_hold_R3: assert property (@(posedge clk) disable iff (rst_int)
    (arr == ARR_SPLIT && !fall_a) |=> (two_q == $past(two_q)));

  assert_bcd_same_cycle_R8: assert property (@(posedge clk) disable iff (rst_int)
    (arr == ARR_BCD && $fell(two_q)) |-> (five_q != $past(five_q)));

  assert_biq_toggle_R6: assert property (@(posedge clk) disable iff (rst_int)
    (arr == ARR_BIQ && two_q != $past(two_q)) |-> ($past(five_q) == QUIN_TOP && five_q == '0));
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter #(
  parameter int N_HALVES    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic [N_HALVES-1:0]   rst_i,
  input  logic [N_HALVES-1:0]   cnt_a_i,
  input  logic [N_HALVES-1:0]   cnt_b_i,
  input  logic [2*N_HALVES-1:0] arr_i,
  output logic [4*N_HALVES-1:0] q_o
);
  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    decade_half #(.SYNC_STAGES(SYNC_STAGES)) u_half (
      .clk     (clk),
      .rst_i   (rst_i[h]),
      .cnt_a_i (cnt_a_i[h]),
      .cnt_b_i (cnt_b_i[h]),
      .arr_i   (arr_i[2*h +: 2]),
      .q_o     (q_o[4*h +: 4])
    );
  end
endmodule

// File: tb/tb_dual_decade_counter.sv
module tb_dual_decade_counter;
  localparam int N = 2;
  localparam int GAP = 5;

  logic           clk = 1'b0;
  logic [N-1:0]   rst;
  logic [N-1:0]   ca, cb;
  logic [2*N-1:0] arr;
  logic [4*N-1:0] q;

  int n_run = 0;
  int n_fail = 0;

  bit mq0 [N];
  int mq5 [N];

  always #2.5 clk = ~clk;

  dual_decade_counter #(.N_HALVES(N)) dut (
    .clk(clk), .rst_i(rst), .cnt_a_i(ca), .cnt_b_i(cb), .arr_i(arr), .q_o(q));

  function automatic logic [3:0] exp_q(int h);
    return {mq5[h][2:0], mq0[h]};
  endfunction

  function automatic int arr_of(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 0;
  endfunction

  task automatic check(int h, string req, logic [3:0] expv);
    n_run++;
    if (q[4*h +: 4] !== expv) begin
      n_fail++;
      $display("FAIL %s half%0d: q=%b expected %b", req, h, q[4*h +: 4], expv);
    end
  endtask

  task automatic check_all(string req);
    for (int h = 0; h < N; h++) check(h, req, exp_q(h));
  endtask

  // model of one falling edge; sel 0 = first input, 1 = second
  task automatic model_fall(int h, int sel);
    int a = arr_of(arr[2*h +: 2]);
    if (sel == 0) begin
      if (a == 1) begin
        if (mq0[h]) mq5[h] = (mq5[h] + 1) % 5;
        mq0[h] = !mq0[h];
      end else if (a == 0) mq0[h] = !mq0[h];
    end else begin
      if (a == 2) begin
        if (mq5[h] == 4) mq0[h] = !mq0[h];
        mq5[h] = (mq5[h] + 1) % 5;
      end else if (a == 0) mq5[h] = (mq5[h] + 1) % 5;
    end
  endtask

  task automatic pulse(int h, int sel);
    @(negedge clk);
    if (sel == 0) ca[h] = 1'b0; else cb[h] = 1'b0;
    if (!rst[h]) model_fall(h, sel);
    repeat (GAP) @(negedge clk);
    if (sel == 0) ca[h] = 1'b1; else cb[h] = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic do_reset(int h);
    @(negedge clk);
    rst[h] = 1'b1;
    #0.5;
    mq0[h] = 0; mq5[h] = 0;
    check(h, "R2 async clear", 4'd0);
    repeat (3) @(negedge clk);
    rst[h] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    void'($urandom(32'h5eed));
    rst = '1; ca = '1; cb = '1; arr = '0;
    for (int h = 0; h < N; h++) begin mq0[h] = 0; mq5[h] = 0; end
    repeat (4) @(negedge clk);
    check_all("R2 reset state");
    rst = '0;
    repeat (4) @(negedge clk);
    check_all("R2 after release");

    // R1 / R3: fall toggles, rise holds
    @(negedge clk); ca[0] = 1'b0; model_fall(0, 0);
    repeat (GAP) @(negedge clk);
    check(0, "R3 fall toggles bit0", exp_q(0));
    ca[0] = 1'b1;
    repeat (GAP) @(negedge clk);
    check(0, "R1 rise no change", exp_q(0));
    pulse(0, 0);
    check(0, "R3 second toggle", 4'b0000);

    // R4: divide-by-5 sequence, bit3 only in state 4
    for (int i = 1; i <= 6; i++) begin
      pulse(0, 1);
      check(0, "R4 quinary step", {3'(i % 5), 1'b0});
    end
    do_reset(0);

    // R5: BCD on half0
    arr[1:0] = 2'b01;
    for (int i = 1; i <= 10; i++) begin
      pulse(0, 0);
      check(0, "R5 bcd count", 4'(i % 10));
    end
    pulse(0, 1);
    check(0, "R5 second input ignored", 4'd0);

    // R8: same-cycle cascade, from count 1 to 2
    pulse(0, 0);
    @(negedge clk); ca[0] = 1'b0; model_fall(0, 0);
    prev = q[3:0];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (q[0] != prev[0]) begin
        n_run++;
        if (q[3:1] == prev[3:1]) begin
          n_fail++;
          $display("FAIL R8 cascade lag: q=%b expected upper bits changed from %b", q[3:0], prev);
        end
      end
      prev = q[3:0];
    end
    ca[0] = 1'b1; repeat (GAP) @(negedge clk);
    check(0, "R8 value after cascade", 4'd2);

    // R6: bi-quinary on half1
    arr[3:2] = 2'b10;
    for (int i = 1; i <= 10; i++) begin
      pulse(1, 1);
      check(1, "R6 biquinary step", {3'(i % 5), 1'((i / 5) % 2)});
    end
    pulse(1, 0);
    check(1, "R6 first input ignored", exp_q(1));
    check(0, "R9 other half untouched", exp_q(0));

    // R7: spare code acts as split
    arr[3:2] = 2'b11;
    pulse(1, 0);
    check(1, "R7 spare toggles bit0", exp_q(1));
    pulse(1, 1);
    check(1, "R7 spare quinary step", exp_q(1));

    // R2: mid-count reset, edges during reset discarded
    pulse(1, 1);
    @(negedge clk); rst[1] = 1'b1; #0.5;
    mq0[1] = 0; mq5[1] = 0;
    check(1, "R2 mid-count clear", 4'd0);
    pulse(1, 0); pulse(1, 1);
    check(1, "R2 held during edges", 4'd0);
    rst[1] = 1'b0; repeat (4) @(negedge clk);
    check(1, "R2 edges discarded", 4'd0);
    check(0, "R9 reset isolated", exp_q(0));

    // random mix
    for (int it = 0; it < 400; it++) begin
      int h = int'($urandom_range(N - 1));
      int op = int'($urandom_range(19));
      if (op == 0) do_reset(h);
      else if (op == 1) arr[2*h +: 2] = 2'($urandom_range(3));
      else pulse(h, op % 2);
      check_all("R9 random vs model");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule